// File: doc/BRIEF.md
# Prescaled interval timer counter

One channel of an up-counting timer reached through a small memory-mapped register port. A power-of-two prescaler turns the system clock into count ticks. The counter runs in one of two modes. In free-running mode it rolls over at its full width. In interval mode it returns to zero one tick after it has matched a programmed limit, and that tick raises an event flag.

The event flag clears when software reads it. It is masked by an enable bit, and the result drives a level interrupt line. Software can stop the counter, resume it, or restart it from zero by writing the run control register. The counter width is a parameter and may be 16 or 32 bits.

The register port has one strobe with a write qualifier. Read data is combinational, and a write takes effect at the clock edge where the strobe is high.

Top module: `ptimer_chan`

## Requirements
- R1: Byte offsets are 0x00 clock config, 0x0C run control, 0x18 count (read-only), 0x24 limit, 0x54 event status (read-only), 0x60 event enable. After reset every register reads 0 and irq is 0. A read of any other offset returns 0.
- R2: Clock config bit 0 enables the prescaler and bits 4:1 hold an exponent N. With the prescaler enabled the count advances once every 2^(N+1) clocks, and with it disabled the count advances every clock. Bit 5 is a clock source select that is stored and read back but does not change counting. The register reads back bits 5:0 as written.
- R3: While run control bit 0 is 0 the count goes up by one per tick. While bit 0 is 1 the count and the prescaler phase hold. Clearing bit 0 resumes counting from the held value. The change takes effect from the cycle after the write.
- R4: Writing 1 to run control bit 4 clears the count and the prescaler phase at that write's clock edge. Bit 4 always reads 0.
- R5: With run control bit 1 = 0 the count wraps from all ones to 0, for example 0xFFFF to 0 at width 16, and the event flag is not set.
- R6: With run control bit 1 = 1, on the tick where the count equals the limit the count becomes 0 and event status bit 0 is set. The period is therefore limit+1 ticks.
- R7: A read of event status returns the flag and clears it. An event arriving in the same cycle as that read stays pending.
- R8: irq is high exactly when event status bit 0 and event enable bit 0 are both 1. The enable takes effect from the cycle after its write.
- R9: Writes to the count and event status registers are ignored. Run control reads back bits 5, 3:0 as written. The limit register is as wide as the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt, event status AND enable |

## Verification
The bench aims at the cycle where an event coincides with a status read. A design that lets the clear win would lose an interrupt, and the next read would return 0 instead of 1.

It also probes these cases:
- The first tick after a restart. An off-by-one prescaler would shift every count by one tick.
- The full-width wraparound in free mode. A design that compared against a stale limit there would raise a spurious event.
- Stop and resume. A counter that kept advancing, or reloaded on resume, would read a value other than the held one.
- The largest divide in use, exponent 10 (divide by 2048). A truncated shift in the divider would show up here.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_CLKCFG = 8'h00;
  localparam logic [7:0] OFS_RUNCFG = 8'h0C;
  localparam logic [7:0] OFS_COUNT  = 8'h18;
  localparam logic [7:0] OFS_LIMIT  = 8'h24;
  localparam logic [7:0] OFS_EVENT  = 8'h54;
  localparam logic [7:0] OFS_EVMASK = 8'h60;

  localparam int EXP_W = 4;
  localparam int PSC_W = (1 << EXP_W) + 1;

  typedef struct packed {
    logic             src_sel;
    logic [EXP_W-1:0] exp;
    logic             psc_en;
  } clkcfg_t;

  typedef struct packed {
    logic       aux5;
    logic [1:0] aux32;
    logic       iv_mode;
    logic       stop;
  } runcfg_t;

  // last prescaler phase for a divide of 2^(e+1)
  function automatic logic [PSC_W-1:0] psc_last(input logic [EXP_W-1:0] e);
    logic [EXP_W:0] sh;
    sh = {1'b0, e} + 1'b1;
    return (PSC_W'(1) << sh) - PSC_W'(1);
  endfunction

endpackage

// File: rtl/ptimer_presc.sv
module ptimer_presc
  import ptimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             psc_en,
  input  logic [EXP_W-1:0] exp,
  input  logic             restart,
  output logic             tick
);

  logic [PSC_W-1:0] phase_q;
  logic             hit;

  assign hit  = !psc_en || (phase_q >= psc_last(exp));
  assign tick = run && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= hit ? '0 : phase_q + 1'b1;
  end

  // a divide of at least 2 never ticks twice in a row
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc_en && !restart) |=> (!tick || !psc_en || $past(restart))); // R2

endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             iv_mode,
  input  logic [CNT_W-1:0] limit,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_value(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] lim,
                                                  input logic iv);
    if (iv && c == lim) return '0;
    return c + 1'b1;
  endfunction

  assign evt = tick && iv_mode && (cnt_q == limit);
  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= next_value(cnt_q, limit, iv_mode);
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q)); // R3
  AST_EVT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !restart) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              evt,
  output logic [31:0]       bus_rdata,
  output clkcfg_t           clkcfg,
  output runcfg_t           runcfg,
  output logic [CNT_W-1:0]  limit,
  output logic              restart,
  output logic              irq
);

  clkcfg_t          clkcfg_q;
  runcfg_t          runcfg_q;
  logic [CNT_W-1:0] limit_q;
  logic             status_q;
  logic             evmask_q;
  logic             rd_evt;
  logic             wdata_unused;

  function automatic logic wr_to(input logic [ADDR_W-1:0] a, input logic s,
                                 input logic w, input logic [7:0] ofs);
    return s && w && (a == ADDR_W'(ofs));
  endfunction

  assign wdata_unused = ^bus_wdata;
  assign rd_evt  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_EVENT));
  assign restart = wr_to(bus_addr, bus_sel, bus_wr, OFS_RUNCFG) && bus_wdata[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkcfg_q <= '0;
      runcfg_q <= '0;
      limit_q  <= '0;
      evmask_q <= 1'b0;
      status_q <= 1'b0;
    end else begin
      if (wr_to(bus_addr, bus_sel, bus_wr, OFS_CLKCFG)) clkcfg_q <= clkcfg_t'(bus_wdata[5:0]);
      if (wr_to(bus_addr, bus_sel, bus_wr, OFS_RUNCFG))
        runcfg_q <= runcfg_t'({bus_wdata[5], bus_wdata[3:0]});
      if (wr_to(bus_addr, bus_sel, bus_wr, OFS_LIMIT))  limit_q  <= bus_wdata[CNT_W-1:0];
      if (wr_to(bus_addr, bus_sel, bus_wr, OFS_EVMASK)) evmask_q <= bus_wdata[0];
      if (evt)         status_q <= 1'b1;
      else if (rd_evt) status_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_W'(OFS_CLKCFG): bus_rdata = 32'(clkcfg_q);
        ADDR_W'(OFS_RUNCFG): bus_rdata = {26'd0, runcfg_q.aux5, 1'b0, runcfg_q.aux32,
                                          runcfg_q.iv_mode, runcfg_q.stop};
        ADDR_W'(OFS_COUNT):  bus_rdata = 32'(cnt_val);
        ADDR_W'(OFS_LIMIT):  bus_rdata = 32'(limit_q);
        ADDR_W'(OFS_EVENT):  bus_rdata = {31'd0, status_q};
        ADDR_W'(OFS_EVMASK): bus_rdata = {31'd0, evmask_q};
        default:             bus_rdata = '0;
      endcase
    end
  end

  assign clkcfg = clkcfg_q;
  assign runcfg = runcfg_q;
  assign limit  = limit_q;
  assign irq    = status_q && evmask_q;

  AST_EVT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status_q); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !evt) |=> !status_q); // R7
  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !evt) |=> !irq); // R8

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  clkcfg_t          clkcfg;
  runcfg_t          runcfg;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             restart;
  logic             tick;
  logic             evt;

  ptimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_val(cnt), .evt(evt),
    .bus_rdata(bus_rdata), .clkcfg(clkcfg), .runcfg(runcfg), .limit(limit),
    .restart(restart), .irq(irq)
  );

  ptimer_presc presc_i (
    .clk(clk), .rst_n(rst_n), .run(!runcfg.stop), .psc_en(clkcfg.psc_en),
    .exp(clkcfg.exp), .restart(restart), .tick(tick)
  );

  ptimer_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .iv_mode(runcfg.iv_mode),
    .limit(limit), .restart(restart), .cnt(cnt), .evt(evt)
  );

  logic src_unused;
  assign src_unused = clkcfg.src_sel;

endmodule

// File: tb/ptimer_chan_tb_top.sv
`timescale 1ns/100ps
module ptimer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  logic [31:0] rd_v;
  logic        irq_v;
  bit          done = 0;

  always #2.5 clk = ~clk;

  ptimer_chan dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  localparam logic [7:0] A_CLK = 8'h00, A_RUN = 8'h0C, A_CNT = 8'h18,
                         A_LIM = 8'h24, A_EVT = 8'h54, A_MSK = 8'h60;

  function automatic int divide(input bit en, input int n);
    return en ? (1 << (n + 1)) : 1;
  endfunction

  function automatic longint exp_count(input int edges, input int d, input bit iv, input int lim);
    longint t = edges / d;
    return iv ? t % (lim + 1) : t % 65536;
  endfunction

  task automatic chk(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 0; wr = 0;
  endtask

  task automatic brd(input logic [7:0] a);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #1 rd_v = rdata; irq_v = irq;
    @(posedge clk); #1 sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values and unmapped offset
    brd(A_CLK); chk("R1 clkcfg", rd_v, 0); chk("R1 irq", irq_v, 0);
    brd(A_RUN); chk("R1 runcfg", rd_v, 0);
    brd(A_LIM); chk("R1 limit", rd_v, 0);
    brd(A_EVT); chk("R1 status", rd_v, 0);
    brd(A_MSK); chk("R1 enable", rd_v, 0);
    brd(8'h30); chk("R1 unmapped", rd_v, 0);

    // R2 clock config readback, R4 / R9 run control readback
    bwr(A_CLK, 32'h3F); brd(A_CLK); chk("R2 clkcfg readback", rd_v, 32'h3F);
    bwr(A_CLK, 32'h0);
    bwr(A_RUN, 32'h3F); brd(A_RUN); chk("R4 R9 runcfg readback", rd_v, 32'h2F);
    bwr(A_RUN, 32'h01);
    bwr(A_LIM, 32'hABCD1234); brd(A_LIM); chk("R9 limit width", rd_v, 32'h1234);

    // R9 writes to read-only registers, counter stopped (R3)
    begin
      logic [31:0] c0;
      brd(A_CNT); c0 = rd_v;
      bwr(A_CNT, 32'h1234); bwr(A_EVT, 32'h1);
      idle(4);
      brd(A_CNT); chk("R9 R3 count write ignored", rd_v, c0);
      brd(A_EVT); chk("R9 status write ignored", rd_v, 0);
    end

    // R3 counting, stop, resume
    bwr(A_RUN, 32'h10); idle(100);
    brd(A_CNT); chk("R3 count up", rd_v, 100);
    bwr(A_RUN, 32'h01); idle(5);
    brd(A_CNT); chk("R3 held", rd_v, 102);
    bwr(A_RUN, 32'h00); idle(7);
    brd(A_CNT); chk("R3 resume", rd_v, 109);

    // R5 full-width wrap, no event
    bwr(A_RUN, 32'h10); idle(65535);
    brd(A_CNT); chk("R5 all ones", rd_v, 32'hFFFF);
    brd(A_CNT); chk("R5 wrap zero", rd_v, 0);
    brd(A_EVT); chk("R5 no event", rd_v, 0);

    // R2 prescaler directed
    bwr(A_RUN, 32'h01); bwr(A_CLK, 32'h09);
    bwr(A_RUN, 32'h10); idle(159);
    brd(A_CNT); chk("R2 div32", rd_v, exp_count(159, 32, 0, 0));
    bwr(A_RUN, 32'h01); bwr(A_CLK, 32'h29);
    bwr(A_RUN, 32'h10); idle(95);
    brd(A_CNT); chk("R2 source bit no effect", rd_v, exp_count(95, 32, 0, 0));
    bwr(A_RUN, 32'h01); bwr(A_CLK, 32'h14);
    bwr(A_RUN, 32'h10); idle(77);
    brd(A_CNT); chk("R2 prescaler off", rd_v, 77);
    bwr(A_RUN, 32'h01); bwr(A_CLK, 32'h15);
    bwr(A_RUN, 32'h10); idle(2047);
    brd(A_CNT); chk("R2 div2048 before tick", rd_v, 0);
    brd(A_CNT); chk("R2 div2048 first tick", rd_v, 1);
    idle(2 * 2048 + 10);
    brd(A_CNT); chk("R2 div2048 later", rd_v, exp_count(2049 + 2 * 2048 + 10, 2048, 0, 0));

    // R6 R7 R8 interval directed, D=1, limit 5
    bwr(A_RUN, 32'h01); bwr(A_CLK, 32'h0); brd(A_EVT);
    bwr(A_LIM, 5); bwr(A_MSK, 1);
    bwr(A_RUN, 32'h12); idle(5);
    brd(A_CNT); chk("R6 at limit", rd_v, 5); chk("R8 irq low before", irq_v, 0);
    brd(A_EVT); chk("R6 status set", rd_v, 1); chk("R8 irq high", irq_v, 1);
    brd(A_EVT); chk("R7 read cleared", rd_v, 0); chk("R8 irq cleared", irq_v, 0);
    idle(3);
    brd(A_EVT); chk("R7 read at event edge", rd_v, 0);
    brd(A_EVT); chk("R7 event kept", rd_v, 1);
    brd(A_CNT); chk("R6 wrapped", rd_v, 13 % 6);
    bwr(A_MSK, 0); idle(4);
    brd(A_CNT); chk("R6 count", rd_v, 19 % 6); chk("R8 masked", irq_v, 0);
    bwr(A_MSK, 1);
    brd(A_CNT); chk("R8 unmasked", irq_v, 1);

    // random interval / free runs
    for (int i = 0; i < 12; i++) begin
      int lim = 1 + ($urandom % 40);
      int n   = $urandom % 5;
      bit en  = $urandom % 2;
      bit iv  = $urandom % 2;
      bit msk = $urandom % 2;
      int d   = divide(en, n);
      int e   = $urandom % ((lim + 1) * d * 2 + 1);
      bit ev;
      bwr(A_RUN, 32'h01); brd(A_EVT);
      bwr(A_LIM, lim); bwr(A_CLK, {27'd0, 4'(n), en}); bwr(A_MSK, {31'd0, msk});
      bwr(A_RUN, iv ? 32'h12 : 32'h10);
      idle(e);
      brd(A_CNT); chk(iv ? "R6 random count" : "R3 random count", rd_v, exp_count(e, d, iv, lim));
      ev = iv && ((e + 1) / d >= lim + 1);
      brd(A_EVT); chk("R6 random status", rd_v, ev); chk("R8 random irq", irq_v, ev && msk);
    end

    finish_run();
  end

endmodule